// File: doc/BRIEF.md
# Two-Byte Converter Result Sequencer

This block delivers each converter result, wider than one byte, over an eight-bit parallel bus as two bytes in turn. It acts as the talker side of a three-wire source handshake. The talker raises data-valid. The listener signals that it is ready for data and that it has accepted data. An end-of-conversion pulse restarts the sequencer and selects the upper byte. The upper byte carries the top result bits in its low positions, and every remaining position repeats the sign bit. Once the listener accepts that byte, the lower eight result bits follow.

The result is held in a register inside the block. A latch pulse from the converter loads this register. While only the first of the two bytes has gone out, a half-sent flag is raised and latch pulses are discarded, so that the two bytes of one transfer always come from the same conversion. The data lines are driven only while the device is in talk mode and a result is pending.

Top module: `adc_byte_sequencer`

## Requirements
- R1: During and directly after reset, `dav_o`, `data_rdy_o`, `half_inh_o` and `dio_oe_o` are 0 and `dio_o` is 0.
- R2: In the cycle after `eoc_i` is sampled high, from any state, `data_rdy_o` is 1, `half_inh_o` and `dav_o` are 0, and the upper byte is selected.
- R3: The upper byte has held result bits [10:8] in bit positions [2:0], and bits [7:3] all equal held result bit 10.
- R4: After the upper byte is accepted, the lower byte is presented, equal to held result bits [7:0].
- R5: `dav_o` rises only in the cycle after one in which `talk_i` and `lsn_rfd_i` are 1 and `lsn_dac_i` is 0, with a byte pending.
- R6: When `dav_o` is 1 and `lsn_dac_i` is sampled high, `dav_o` is 0 in the next cycle and the sequencer moves to the next byte.
- R7: `half_inh_o` is 1 from the cycle after the upper byte's acceptance until the lower byte's acceptance, and it implies `data_rdy_o`.
- R8: After the lower byte is accepted, `data_rdy_o` and `half_inh_o` are 0, and listener activity raises no `dav_o` until the next `eoc_i`.
- R9: While `talk_i` is 0, `dio_oe_o` is 0 and `dio_o` is 0. If `talk_i` falls while `dav_o` is 1, `dav_o` drops in the next cycle and the same byte is offered again later.
- R10: A `latch_i` pulse loads `result_i` into the held result only while `half_inh_o` is 0. While `half_inh_o` is 1 it is ignored, which is visible in the lower byte that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | RES_W (11) | Converter result, two's complement |
| latch_i | input | 1 | Converter latch pulse |
| eoc_i | input | 1 | End-of-conversion pulse |
| talk_i | input | 1 | Talk mode active |
| lsn_rfd_i | input | 1 | Listener ready for data |
| lsn_dac_i | input | 1 | Listener data accepted |
| dio_o | output | BUS_W (8) | Byte on the data lines |
| dio_oe_o | output | 1 | Data-line driver enable |
| dav_o | output | 1 | Data valid |
| data_rdy_o | output | 1 | A result is pending transfer |
| half_inh_o | output | 1 | Half sent: latch pulses are blocked |

## Verification
The assertions check these rules on every cycle:
- the handshake ordering: data-valid rises only after the listener is ready, and it falls after acceptance or after talk mode ends;
- the released bus outside talk mode;
- the restart on end of conversion;
- the stability of the held result while the half-sent flag is up.

The bytes' contents can only be shown by the bench's scenarios:
- the sign fill for negative and positive results;
- the lower byte that follows;
- a latch pulse that is ignored mid-transfer and shows up as an unchanged lower byte;
- a restart from the middle of a transfer.

A behavioural reference model runs beside the design and compares every output on every clock.

// File: rtl/abs_pkg.sv
package abs_pkg;
   // Sequencer phases: which byte is pending and whether it is offered.
   typedef enum logic [2:0] {
      SQ_IDLE     = 3'd0,
      SQ_HI_WAIT  = 3'd1,
      SQ_HI_VALID = 3'd2,
      SQ_LO_WAIT  = 3'd3,
      SQ_LO_VALID = 3'd4
   } seq_st_t;

   function automatic logic is_lo(input seq_st_t s);
      return (s == SQ_LO_WAIT) || (s == SQ_LO_VALID);
   endfunction

   function automatic logic is_valid(input seq_st_t s);
      return (s == SQ_HI_VALID) || (s == SQ_LO_VALID);
   endfunction
endpackage

// File: rtl/abs_result_hold.sv
module abs_result_hold #(
   parameter int RES_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             block_i,
   input  logic [RES_W-1:0] data_i,
   output logic [RES_W-1:0] held_o
);
   logic [RES_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 held_q <= '0;
      else if (load_i && !block_i) held_q <= data_i;
   end

   assign held_o = held_q;
endmodule

// File: rtl/abs_byte_mux.sv
module abs_byte_mux #(
   parameter int RES_W        = 11,
   parameter int BUS_W        = 8,
   parameter bit HI_FILL_SIGN = 1'b1
) (
   input  logic [RES_W-1:0] held_i,
   input  logic             sel_lo_i,
   input  logic             drive_i,
   output logic [BUS_W-1:0] byte_o
);
   localparam int HI_BITS = RES_W - BUS_W;
   localparam int FILL_W  = BUS_W - HI_BITS;

   logic [BUS_W-1:0] hi_byte;
   logic [BUS_W-1:0] lo_byte;
   logic [HI_BITS-1:0] top_bits;

   assign top_bits = held_i[RES_W-1 -: HI_BITS];
   assign lo_byte  = held_i[BUS_W-1:0];

   generate
      if (FILL_W == 0) begin : g_no_fill
         assign hi_byte = top_bits;
      end else if (HI_FILL_SIGN) begin : g_sign_fill
         assign hi_byte = {{FILL_W{held_i[RES_W-1]}}, top_bits};
      end else begin : g_zero_fill
         assign hi_byte = {{FILL_W{1'b0}}, top_bits};
      end
   endgenerate

   always_comb begin
      if (!drive_i)      byte_o = '0;
      else if (sel_lo_i) byte_o = lo_byte;
      else               byte_o = hi_byte;
   end
endmodule

// File: rtl/abs_handshake_fsm.sv
module abs_handshake_fsm
   import abs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_i,
   input  logic talk_i,
   input  logic rfd_i,
   input  logic dac_i,
   output logic dav_o,
   output logic pend_o,
   output logic half_o,
   output logic sel_lo_o
);
   seq_st_t st_q, st_d;
   logic    may_offer;

   assign may_offer = talk_i && rfd_i && !dac_i;

   always_comb begin
      st_d = st_q;
      if (eoc_i) begin
         st_d = SQ_HI_WAIT;
      end else begin
         unique case (st_q)
            SQ_IDLE:     st_d = SQ_IDLE;
            SQ_HI_WAIT:  if (may_offer) st_d = SQ_HI_VALID;
            SQ_HI_VALID: begin
               if (dac_i)        st_d = SQ_LO_WAIT;
               else if (!talk_i) st_d = SQ_HI_WAIT;
            end
            SQ_LO_WAIT:  if (may_offer) st_d = SQ_LO_VALID;
            SQ_LO_VALID: begin
               if (dac_i)        st_d = SQ_IDLE;
               else if (!talk_i) st_d = SQ_LO_WAIT;
            end
            default:     st_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

   assign dav_o    = is_valid(st_q);
   assign pend_o   = (st_q != SQ_IDLE);
   assign half_o   = is_lo(st_q);
   assign sel_lo_o = is_lo(st_q);
endmodule

// File: rtl/adc_byte_sequencer.sv
module adc_byte_sequencer #(
   parameter int RES_W        = 11,
   parameter int BUS_W        = 8,
   parameter bit HI_FILL_SIGN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RES_W-1:0] result_i,
   input  logic             latch_i,
   input  logic             eoc_i,
   input  logic             talk_i,
   input  logic             lsn_rfd_i,
   input  logic             lsn_dac_i,
   output logic [BUS_W-1:0] dio_o,
   output logic             dio_oe_o,
   output logic             dav_o,
   output logic             data_rdy_o,
   output logic             half_inh_o
);
   generate
      if (RES_W <= BUS_W || RES_W > 2 * BUS_W) begin : g_bad_width
         $error("adc_byte_sequencer: RES_W must lie in (BUS_W, 2*BUS_W]");
      end
   endgenerate

   logic [RES_W-1:0] held_q;
   logic             sel_lo;
   logic             pend;
   logic             half;
   logic             drive;

   abs_handshake_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .eoc_i    (eoc_i),
      .talk_i   (talk_i),
      .rfd_i    (lsn_rfd_i),
      .dac_i    (lsn_dac_i),
      .dav_o    (dav_o),
      .pend_o   (pend),
      .half_o   (half),
      .sel_lo_o (sel_lo)
   );

   abs_result_hold #(.RES_W(RES_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (latch_i),
      .block_i (half),
      .data_i  (result_i),
      .held_o  (held_q)
   );

   assign drive = talk_i && pend;

   abs_byte_mux #(
      .RES_W        (RES_W),
      .BUS_W        (BUS_W),
      .HI_FILL_SIGN (HI_FILL_SIGN)
   ) u_mux (
      .held_i   (held_q),
      .sel_lo_i (sel_lo),
      .drive_i  (drive),
      .byte_o   (dio_o)
   );

   assign dio_oe_o   = drive;
   assign data_rdy_o = pend;
   assign half_inh_o = half;
endmodule

// File: rtl/abs_checker.sv
module abs_checker #(
   parameter int RES_W = 11,
   parameter int BUS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eoc_i,
   input logic             latch_i,
   input logic             talk_i,
   input logic             lsn_rfd_i,
   input logic             lsn_dac_i,
   input logic [BUS_W-1:0] dio_o,
   input logic             dio_oe_o,
   input logic             dav_o,
   input logic             data_rdy_o,
   input logic             half_inh_o,
   input logic [RES_W-1:0] held_q
);
   a_r2_eoc_restart: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_i |=> data_rdy_o && !half_inh_o && !dav_o);

   a_r5_dav_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dav_o) |-> $past(talk_i && lsn_rfd_i && !lsn_dac_i));

   a_r6_dav_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      dav_o && lsn_dac_i && !eoc_i |=> !dav_o);

   a_r7_half_implies_pending: assert property (@(posedge clk) disable iff (!rst_n)
      half_inh_o |-> data_rdy_o);

   a_r8_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(half_inh_o) && !$past(eoc_i) |-> !data_rdy_o);

   a_r9_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      !talk_i |-> !dio_oe_o && dio_o == '0);

   a_r9_dav_needs_talk: assert property (@(posedge clk) disable iff (!rst_n)
      dav_o && !talk_i && !eoc_i |=> !dav_o);

   a_r10_latch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      latch_i && half_inh_o |=> $stable(held_q));
endmodule

bind adc_byte_sequencer abs_checker #(.RES_W(RES_W), .BUS_W(BUS_W)) u_abs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .eoc_i      (eoc_i),
   .latch_i    (latch_i),
   .talk_i     (talk_i),
   .lsn_rfd_i  (lsn_rfd_i),
   .lsn_dac_i  (lsn_dac_i),
   .dio_o      (dio_o),
   .dio_oe_o   (dio_oe_o),
   .dav_o      (dav_o),
   .data_rdy_o (data_rdy_o),
   .half_inh_o (half_inh_o),
   .held_q     (held_q)
);

// File: tb/tb_adc_byte_sequencer.sv
`timescale 1ns/1ps
module tb_adc_byte_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] result_i = '0;
   logic        latch_i = 1'b0;
   logic        eoc_i = 1'b0;
   logic        talk_i = 1'b0;
   logic        lsn_rfd_i = 1'b0;
   logic        lsn_dac_i = 1'b0;
   logic [7:0]  dio_o;
   logic        dio_oe_o, dav_o, data_rdy_o, half_inh_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   adc_byte_sequencer dut (
      .clk(clk), .rst_n(rst_n), .result_i(result_i), .latch_i(latch_i),
      .eoc_i(eoc_i), .talk_i(talk_i), .lsn_rfd_i(lsn_rfd_i), .lsn_dac_i(lsn_dac_i),
      .dio_o(dio_o), .dio_oe_o(dio_oe_o), .dav_o(dav_o),
      .data_rdy_o(data_rdy_o), .half_inh_o(half_inh_o)
   );

   // Behavioural reference: 0 idle, 1 upper pending, 2 upper offered,
   // 3 lower pending, 4 lower offered.
   int          ms = 0;
   logic [10:0] m_held = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0;
         m_held = '0;
      end else begin
         if (latch_i && ms < 3) m_held = result_i;
         if (eoc_i) ms = 1;
         else if ((ms == 1 || ms == 3) && talk_i && lsn_rfd_i && !lsn_dac_i) ms = ms + 1;
         else if ((ms == 2 || ms == 4) && lsn_dac_i) ms = (ms == 2) ? 3 : 0;
         else if ((ms == 2 || ms == 4) && !talk_i) ms = ms - 1;
      end
   end

   function automatic logic [7:0] upper_of(input logic [10:0] v);
      return {{5{v[10]}}, v[10:8]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Compare with the reference on every cycle.
   always @(negedge clk) begin
      logic       e_rdy, e_inh, e_dav, e_oe;
      logic [7:0] e_dio;
      e_rdy = (ms != 0);
      e_inh = (ms >= 3);
      e_dav = (ms == 2 || ms == 4);
      e_oe  = talk_i && e_rdy;
      e_dio = !e_oe ? 8'h00 : (ms >= 3 ? m_held[7:0] : upper_of(m_held));
      chk(dav_o == e_dav, "R5/R6 dav", dav_o, e_dav);
      chk(data_rdy_o == e_rdy, "R2/R8 data_rdy", data_rdy_o, e_rdy);
      chk(half_inh_o == e_inh, "R7 half_inh", half_inh_o, e_inh);
      chk(dio_oe_o == e_oe, "R9 dio_oe", dio_oe_o, e_oe);
      chk(dio_o == e_dio, "R3/R4 dio", dio_o, e_dio);
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic pulse_eoc();
      eoc_i = 1'b1;
      tick();
      eoc_i = 1'b0;
   endtask

   task automatic load(input logic [10:0] v);
      result_i = v;
      latch_i  = 1'b1;
      tick();
      latch_i  = 1'b0;
   endtask

   task automatic get_byte(output logic [7:0] b);
      lsn_rfd_i = 1'b1;
      lsn_dac_i = 1'b0;
      for (int i = 0; i < 50; i++) begin
         tick();
         if (dav_o) break;
      end
      b = dio_o;
      lsn_rfd_i = 1'b0;
      lsn_dac_i = 1'b1;
      for (int i = 0; i < 50; i++) begin
         tick();
         if (!dav_o) break;
      end
      lsn_dac_i = 1'b0;
      tick();
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] b;
      repeat (3) tick();
      chk(!dav_o && !data_rdy_o && !half_inh_o && !dio_oe_o && dio_o == 0,
          "R1 reset outputs", {dav_o, data_rdy_o, half_inh_o, dio_oe_o}, 0);
      rst_n = 1'b1;
      tick();
      chk(!dav_o && !data_rdy_o, "R1 after reset", {dav_o, data_rdy_o}, 0);

      // Negative result: 0x5A3
      talk_i = 1'b1;
      load(11'h5A3);
      pulse_eoc();
      chk(data_rdy_o && !half_inh_o && !dav_o, "R2 eoc starts upper",
          {data_rdy_o, half_inh_o, dav_o}, 3'b100);
      get_byte(b);
      chk(b == 8'hFD, "R3 upper byte sign fill", b, 8'hFD);
      chk(half_inh_o == 1'b1, "R7 half sent flag", half_inh_o, 1);
      load(11'h123);   // must be ignored
      get_byte(b);
      chk(b == 8'hA3, "R4/R10 lower byte keeps old result", b, 8'hA3);
      chk(!data_rdy_o && !half_inh_o, "R8 done clears flags",
          {data_rdy_o, half_inh_o}, 0);
      lsn_rfd_i = 1'b1;
      repeat (4) tick();
      chk(!dav_o, "R8 no dav without eoc", dav_o, 0);
      lsn_rfd_i = 1'b0;

      // Positive result: 0x2F1
      load(11'h2F1);
      pulse_eoc();
      get_byte(b);
      chk(b == 8'h02, "R3 upper byte positive", b, 8'h02);
      get_byte(b);
      chk(b == 8'hF1, "R4 lower byte positive", b, 8'hF1);

      // R5: not ready, then ready but accept still high
      load(11'h400);
      pulse_eoc();
      repeat (3) tick();
      chk(!dav_o, "R5 no dav while listener not ready", dav_o, 0);
      lsn_rfd_i = 1'b1;
      lsn_dac_i = 1'b1;
      repeat (3) tick();
      chk(!dav_o, "R5 no dav while accept high", dav_o, 0);
      lsn_dac_i = 1'b0;
      tick();
      chk(dav_o && dio_o == 8'hFC, "R5 dav after ready", {dav_o, dio_o}, 9'h1FC);

      // R9: talk drops while offered
      talk_i = 1'b0;
      tick();
      chk(!dav_o && !dio_oe_o && dio_o == 0, "R9 released when not talking",
          {dav_o, dio_oe_o, dio_o}, 0);
      talk_i = 1'b1;
      get_byte(b);
      chk(b == 8'hFC, "R9 same byte offered again", b, 8'hFC);

      // R2: restart mid transfer, then new result allowed while idle-upper
      chk(half_inh_o, "R7 half sent before restart", half_inh_o, 1);
      load(11'h0AA);   // blocked (R10)
      pulse_eoc();
      chk(data_rdy_o && !half_inh_o && dio_o == 8'hFC, "R2 restart selects upper",
          {data_rdy_o, half_inh_o, dio_o}, 10'h2FC);
      load(11'h0AA);   // accepted now: half flag low (R10)
      get_byte(b);
      chk(b == 8'h00, "R10 latch accepted while not half sent", b, 8'h00);
      get_byte(b);
      chk(b == 8'hAA, "R4 lower byte after reload", b, 8'hAA);

      // talk off with pending result: bus stays released
      talk_i = 1'b0;
      pulse_eoc();
      lsn_rfd_i = 1'b1;
      repeat (3) tick();
      chk(!dav_o && !dio_oe_o && data_rdy_o, "R9 pending but not talking",
          {dav_o, dio_oe_o, data_rdy_o}, 1);
      lsn_rfd_i = 1'b0;

      repeat (2) tick();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule